// File: doc/BRIEF.md
# Free-running 64-bit counter with coherent snapshot

This block keeps a 64-bit up-counter that advances on every cycle in which the reference tick is high; the tick comes from the 24 MHz oscillator. The counter cannot be read in one bus access. Software first asks for a snapshot, which copies the whole counter into shadow registers at one instant. It then reads the two 32-bit halves of that copy.

The bus side is a plain 32-bit register port. To take a snapshot, software writes a 1 to bit 1 of the control word. That bit then reads back as 1 while the capture is in flight and clears by itself once the shadow registers hold the new value. After that, the high and low words can be read in any order and with any gap between them. Both come from the same count, and they stay frozen until the next request completes. The live counter keeps running throughout, and it rolls over from all-ones to zero silently.

Top module: `snap_cnt_top`

## Requirements
- R1: While `rst` is high the counter loads `INIT_VAL`, the snapshot is zero, `latch_busy` is 0 and `bus_rdata` is 0.
- R2: The counter adds one on each clock edge where `ref_tick` is 1 and holds otherwise; two snapshots taken with `ref_tick` held at 0 between them are equal.
- R3: A write to offset 0xA0 with `bus_wdata` bit 1 set, while idle, starts a capture, and `latch_busy` is 1 from the next cycle.
- R4: `latch_busy` stays 1 for exactly `LATCH_DLY` cycles and then clears by itself; the shadow registers load on the edge that clears it.
- R5: The shadow registers take the whole 64-bit counter value at a single edge, so the difference between two snapshots equals the number of ticked cycles between their requests.
- R6: The shadow registers and `snap_lo`/`snap_hi` keep their value until the next capture completes, while the counter keeps running.
- R7: These writes have no effect: a write to 0xA0 with bit 1 clear, a write to any other offset, and a request made while a capture is in flight.
- R8: A read is registered. The cycle after `bus_re`, `bus_rdata` holds one of these: for 0xA0, the busy flag in bit 1 with all other bits 0; for 0xA4, the low shadow word; for 0xA8, the high shadow word; for any other offset, zero. `bus_rdata` holds its value when `bus_re` is low.
- R9: The counter wraps from all-ones to zero with no flag, and the carry reaches the high word in the same capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Counter advance enable from the reference oscillator |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| snap_lo | output | DATA_W | Low word of the shadow registers |
| snap_hi | output | DATA_W | High word of the shadow registers |
| latch_busy | output | 1 | Capture in flight |

## Verification
The assertions check the following on every cycle: the counter steps exactly with the tick, busy rises after an accepted request, busy lasts exactly `LATCH_DLY` cycles, the shadow value equals the counter at the edge that clears busy and at no other edge, and read data holds when no read is made. Some behaviour can only be shown by the bench's scenarios, through register reads. These are: that two 32-bit reads form one coherent value, that a wrap carries into the high word, that snapshot differences match the cycles elapsed, and that bit-clear writes, writes to other offsets and overlapping requests are ignored.

// File: rtl/snap_cnt_pkg.sv
package snap_cnt_pkg;
  // byte offsets decoded by the register port
  localparam logic [7:0] OFF_CTRL = 8'hA0;
  localparam logic [7:0] OFF_LO   = 8'hA4;
  localparam logic [7:0] OFF_HI   = 8'hA8;
  // control word bit that requests a capture and reads back busy
  localparam int unsigned REQ_BIT = 1;

  typedef enum logic [1:0] {
    SEL_CTRL,
    SEL_LO,
    SEL_HI,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/snap_cnt_free.sv
module snap_cnt_free #(
  parameter int unsigned      CNT_W    = 64,
  parameter logic [CNT_W-1:0] INIT_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // wraps naturally from all-ones to zero
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= INIT_VAL;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/snap_cnt_latch.sv
module snap_cnt_latch #(
  parameter int unsigned CNT_W     = 64,
  parameter int unsigned LATCH_DLY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] snap_o
);
  logic [LATCH_DLY-1:0] pipe_q;
  logic                 busy_q;
  logic                 start;
  logic                 done;
  logic [CNT_W-1:0]     snap_q;

  // a request while a capture is in flight is dropped
  assign start = req_i & ~busy_q;
  assign done  = pipe_q[LATCH_DLY-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q[0] <= 1'b0;
    end else begin
      pipe_q[0] <= start;
    end
  end

  generate
    for (genvar i = 1; i < int'(LATCH_DLY); i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe_q[i] <= 1'b0;
        end else begin
          pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
    end else if (done) begin
      snap_q <= cnt_i;
    end
  end

  assign busy_o = busy_q;
  assign snap_o = snap_q;
endmodule

// File: rtl/snap_cnt_regs.sv
module snap_cnt_regs
  import snap_cnt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                re_i,
  input  logic                busy_i,
  input  logic [2*DATA_W-1:0] snap_i,
  output logic                req_o,
  output logic [DATA_W-1:0]   rdata_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    if (addr_i == ADDR_W'(OFF_CTRL)) begin
      sel = SEL_CTRL;
    end else if (addr_i == ADDR_W'(OFF_LO)) begin
      sel = SEL_LO;
    end else if (addr_i == ADDR_W'(OFF_HI)) begin
      sel = SEL_HI;
    end else begin
      sel = SEL_NONE;
    end
  end

  assign req_o = we_i & (sel == SEL_CTRL) & wdata_i[REQ_BIT];

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CTRL: rd_mux[REQ_BIT] = busy_i;
      SEL_LO:   rd_mux = snap_i[DATA_W-1:0];
      SEL_HI:   rd_mux = snap_i[2*DATA_W-1:DATA_W];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (re_i) begin
      rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/snap_cnt_top.sv
module snap_cnt_top #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LATCH_DLY = 2,
  parameter logic [2*DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] snap_lo,
  output logic [DATA_W-1:0] snap_hi,
  output logic              latch_busy
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] snap_w;
  logic             req_w;
  logic             busy_w;

  snap_cnt_free #(
    .CNT_W    (CNT_W),
    .INIT_VAL (INIT_VAL)
  ) u_free (
    .clk    (clk),
    .rst    (rst),
    .tick_i (ref_tick),
    .cnt_o  (cnt_w)
  );

  snap_cnt_latch #(
    .CNT_W     (CNT_W),
    .LATCH_DLY (LATCH_DLY)
  ) u_latch (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_w),
    .cnt_i  (cnt_w),
    .busy_o (busy_w),
    .snap_o (snap_w)
  );

  snap_cnt_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr),
    .we_i    (bus_we),
    .wdata_i (bus_wdata),
    .re_i    (bus_re),
    .busy_i  (busy_w),
    .snap_i  (snap_w),
    .req_o   (req_w),
    .rdata_o (bus_rdata)
  );

  assign snap_lo    = snap_w[DATA_W-1:0];
  assign snap_hi    = snap_w[CNT_W-1:DATA_W];
  assign latch_busy = busy_w;
endmodule

// File: rtl/snap_cnt_chk.sv
module snap_cnt_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LATCH_DLY = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic [2*DATA_W-1:0] cnt,
  input logic                req,
  input logic                busy,
  input logic [2*DATA_W-1:0] snap,
  input logic                re,
  input logic [DATA_W-1:0]   rdata
);
  localparam int unsigned LEN_W = $clog2(LATCH_DLY + 1) + 1;

  logic [LEN_W-1:0] blen_q;

  // cycles of busy seen before the current one
  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      blen_q <= '0;
    end else begin
      blen_q <= blen_q + 1'b1;
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (cnt == ($past(tick) ? $past(cnt) + 1'b1 : $past(cnt))));

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> busy);

  // R4
  busy_len_max_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (blen_q < LEN_W'(LATCH_DLY)));

  // R4
  busy_len_exact_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(blen_q) == LEN_W'(LATCH_DLY - 1)));

  // R5
  snap_value_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $fell(busy)) |-> (snap == $past(cnt)));

  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> $stable(snap));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(re)) |-> $stable(rdata));
endmodule

bind snap_cnt_top snap_cnt_chk #(
  .DATA_W    (DATA_W),
  .LATCH_DLY (LATCH_DLY)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .tick  (ref_tick),
  .cnt   (cnt_w),
  .req   (req_w),
  .busy  (latch_busy),
  .snap  ({snap_hi, snap_lo}),
  .re    (bus_re),
  .rdata (bus_rdata)
);

// File: tb/sim_snap_cnt_top.sv
module sim_snap_cnt_top;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DLY    = 2;
  localparam logic [63:0] INIT   = 64'hFFFF_FFFF_FFFF_FFF0;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ref_tick = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              bus_re = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic [DATA_W-1:0] snap_lo;
  logic [DATA_W-1:0] snap_hi;
  logic              latch_busy;

  int checks = 0;
  int fails  = 0;
  longint unsigned cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  snap_cnt_top #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LATCH_DLY (DLY),
    .INIT_VAL  (INIT)
  ) u0 (
    .clk        (clk),
    .rst        (rst),
    .ref_tick   (ref_tick),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .snap_lo    (snap_lo),
    .snap_hi    (snap_hi),
    .latch_busy (latch_busy)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all bus tasks are entered and left at a falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic poll_idle();
    logic [31:0] v;
    int n = 0;
    do begin
      bus_read(8'hA0, v);
      n++;
    end while (v[1] && n < 20);
    check(v[1] == 1'b0, "R4 busy self-clears", 64'(v), 64'h0);
  endtask

  task automatic snapshot(output logic [63:0] s, output longint unsigned at);
    logic [31:0] hi, lo;
    at = cyc;
    bus_write(8'hA0, 32'h2);
    poll_idle();
    bus_read(8'hA8, hi);
    bus_read(8'hA4, lo);
    s = {hi, lo};
  endtask

  task automatic t_reset();
    check(latch_busy == 1'b0, "R1 busy after reset", 64'(latch_busy), 64'h0);
    check(snap_lo == '0 && snap_hi == '0, "R1 snapshot after reset", {snap_hi, snap_lo}, 64'h0);
    check(bus_rdata == '0, "R1 rdata after reset", 64'(bus_rdata), 64'h0);
  endtask

  task automatic t_wrap();
    logic [63:0] a, b;
    longint unsigned ca, cb;
    snapshot(a, ca);
    check(a[63:32] == 32'hFFFF_FFFF, "R9 high word before wrap", a, INIT);
    repeat (30) @(negedge clk);
    snapshot(b, cb);
    check(b[63:32] == 32'h0 && b[31:0] < 32'd100, "R9 wrapped to zero", b, 64'd50);
    check(b - a == 64'(cb - ca), "R5 snapshot difference", b - a, 64'(cb - ca));
    check({snap_hi, snap_lo} == b, "R5 ports match reads", {snap_hi, snap_lo}, b);
  endtask

  task automatic t_delta();
    logic [63:0] a, b;
    longint unsigned ca, cb;
    snapshot(a, ca);
    repeat (37) @(negedge clk);
    snapshot(b, cb);
    check(b - a == 64'(cb - ca), "R5 second difference", b - a, 64'(cb - ca));
  endtask

  task automatic t_hold();
    logic [63:0] a, b;
    longint unsigned ca;
    logic [31:0] hi, lo;
    snapshot(a, ca);
    repeat (40) @(negedge clk);
    bus_read(8'hA8, hi);
    bus_read(8'hA4, lo);
    b = {hi, lo};
    check(b == a, "R6 snapshot holds", b, a);
    check({snap_hi, snap_lo} == a, "R6 ports hold", {snap_hi, snap_lo}, a);
  endtask

  task automatic t_gate();
    logic [63:0] a, b;
    longint unsigned ca, cb;
    ref_tick = 1'b0;
    @(negedge clk);
    snapshot(a, ca);
    repeat (20) @(negedge clk);
    snapshot(b, cb);
    check(b == a, "R2 counter holds without tick", b, a);
    ref_tick = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_latency();
    int n = 0;
    bus_write(8'hA0, 32'h2);
    check(latch_busy == 1'b1, "R3 busy rises", 64'(latch_busy), 64'h1);
    while (latch_busy && n < 20) begin
      n++;
      @(negedge clk);
    end
    check(n == int'(DLY), "R4 busy length", 64'(n), 64'(DLY));
  endtask

  task automatic t_ctrl_read();
    logic [31:0] v;
    bus_write(8'hA0, 32'h2);
    bus_read(8'hA0, v);
    check(v == 32'h2, "R8 control reads busy in bit 1", 64'(v), 64'h2);
    poll_idle();
    bus_read(8'hA0, v);
    check(v == 32'h0, "R8 control reads zero when idle", 64'(v), 64'h0);
    bus_read(8'h10, v);
    check(v == 32'h0, "R8 unmapped offset reads zero", 64'(v), 64'h0);
  endtask

  task automatic t_ignore();
    logic [63:0] s;
    s = {snap_hi, snap_lo};
    bus_write(8'hA0, 32'hFFFF_FFFD);
    check(latch_busy == 1'b0, "R7 bit 1 clear ignored", 64'(latch_busy), 64'h0);
    bus_write(8'hA4, 32'h2);
    check(latch_busy == 1'b0, "R7 other offset ignored", 64'(latch_busy), 64'h0);
    repeat (3) @(negedge clk);
    check({snap_hi, snap_lo} == s, "R7 snapshot untouched", {snap_hi, snap_lo}, s);
    // second request while busy must not extend the capture
    bus_write(8'hA0, 32'h2);
    bus_write(8'hA0, 32'h2);
    check(latch_busy == 1'b1, "R7 busy during overlap", 64'(latch_busy), 64'h1);
    @(negedge clk);
    check(latch_busy == 1'b0, "R7 overlapping request dropped", 64'(latch_busy), 64'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_wrap();
    t_delta();
    t_hold();
    t_gate();
    t_latency();
    t_ctrl_read();
    t_ignore();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule